// File: doc/BRIEF.md
# Two-Level Logic Analyser Trigger

This block watches a bus of probe lines on each sample clock and decides when a capture buffer downstream should start storing. Every probe line has its own setting: it must be low, it must be high, or it does not care. All lines of one condition have to agree on the same sample for that condition to be met.

The trigger works in one of two modes. In the single mode the first condition alone fires the trigger. In the sequenced mode the first condition only raises a status flag, and the trigger fires when the second condition is met on a later sample. The block does nothing until an arm command arrives. It then reports that it is armed, shows whether the first stage has been met, and sends out a trigger pulse one cycle wide. Next to the pulse it gives out a copy of the probe bus, delayed so that the pulse bit and the sample that caused it appear together. That word can be written straight into the capture memory.

Top module: `seq_trigger`

## Requirements
- R1: After reset, `armed`, `stage1_met`, `fired` and `trig_pulse` are all low.
- R2: An `arm` pulse while not armed sets `armed` on the next clock and clears `stage1_met` and `fired`.
- R3: For each line i, the line matches when its care bit is 0, or when the sampled probe bit equals its value bit. A condition is met when every line matches, so with all care bits 0 the condition always holds.
- R4: Probes are registered once before they are compared. A matching probe value sampled at clock edge N gives `trig_pulse` high after edge N+1, for exactly one cycle.
- R5: With `two_level` at 0 the trigger fires when the first condition matches. `stage1_met` stays low, and `armed` drops when the trigger fires.
- R6: With `two_level` at 1, `stage1_met` rises on the edge after a first-condition match and then stays high. The trigger fires only when the second condition matches while `stage1_met` is already high. A second-condition match on the same sample as the first match, or before it, does nothing.
- R7: The trigger fires at most once per arm. `fired` stays high after the pulse until a disarm or a new arm.
- R8: `disarm` clears `armed`, `stage1_met`, `fired` and `trig_pulse` on the next edge. When both `disarm` and `arm` are given, `disarm` wins.
- R9: `cap_data` is {`trig_pulse`, probe delayed by two registers}. Its top bit is set on the same cycle as the pulse, and its lower bits hold the sample that caused the pulse.
- R10: While not armed, probe matches have no effect on `trig_pulse`, `stage1_met` or `fired`.
- R11: An `arm` pulse while already armed is ignored, so `stage1_met` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | Arm command pulse |
| disarm | input | 1 | Disarm command pulse |
| two_level | input | 1 | 1 selects the two-stage sequence |
| c1_value | input | LINES | First condition, required level per line |
| c1_care | input | LINES | First condition, 1 means the line is compared |
| c2_value | input | LINES | Second condition, required level per line |
| c2_care | input | LINES | Second condition, 1 means the line is compared |
| probe | input | LINES | Probe lines under observation |
| armed | output | 1 | Block is armed and waiting for a trigger |
| stage1_met | output | 1 | First stage satisfied (sequenced mode) |
| fired | output | 1 | Trigger has fired since the last arm |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| cap_data | output | LINES+1 | {trig_pulse, delayed probe} for the capture path |

## Verification
State outputs change on the edge after a command: `armed` and the clears from `disarm` show one edge after the command is sampled. A probe value needs two edges to reach `trig_pulse`, one to register it and one to update the state. The bench drives inputs on the falling edge and reads outputs on the next falling edge after the edge where they are due. The exhaustive sweep over value, care and probe holds each probe value through the disarm and arm edges, so the compare sees a stable sample when the pulse falls due.

// File: rtl/trig_pkg.sv
package trig_pkg;
    typedef struct packed {
        logic armed;
        logic first;
        logic fired;
        logic pulse;
    } trig_state_t;

    localparam trig_state_t TRIG_IDLE = '{armed: 1'b0, first: 1'b0, fired: 1'b0, pulse: 1'b0};
endpackage

// File: rtl/trig_match.sv
module trig_match #(
    parameter int LINES = 8
) (
    input  logic [LINES-1:0] want,
    input  logic [LINES-1:0] care,
    input  logic [LINES-1:0] sample,
    output logic             hit
);
    logic [LINES-1:0] line_ok;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign line_ok[i] = ~care[i] | (sample[i] ~^ want[i]);
    end

    assign hit = &line_ok;
endmodule

// File: rtl/trig_seq.sv
module trig_seq
    import trig_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        arm,
    input  logic        disarm,
    input  logic        two_level,
    input  logic        hit1,
    input  logic        hit2,
    output trig_state_t st
);
    trig_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (disarm) begin
            st_d = TRIG_IDLE;
        end else if (arm && !st_q.armed) begin
            st_d       = TRIG_IDLE;
            st_d.armed = 1'b1;
        end else if (st_q.armed && !st_q.fired) begin
            if (two_level && !st_q.first) begin
                if (hit1) begin
                    st_d.first = 1'b1;
                end
            end else if ((two_level && hit2) || (!two_level && hit1)) begin
                st_d.pulse = 1'b1;
                st_d.fired = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= TRIG_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/seq_trigger.sv
module seq_trigger
    import trig_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             disarm,
    input  logic             two_level,
    input  logic [LINES-1:0] c1_value,
    input  logic [LINES-1:0] c1_care,
    input  logic [LINES-1:0] c2_value,
    input  logic [LINES-1:0] c2_care,
    input  logic [LINES-1:0] probe,
    output logic             armed,
    output logic             stage1_met,
    output logic             fired,
    output logic             trig_pulse,
    output logic [LINES:0]   cap_data
);
    localparam int CAPW = LINES + 1;

    logic [LINES-1:0] samp_d, samp_q;
    logic [LINES-1:0] dly_d, dly_q;
    logic             hit1, hit2;
    trig_state_t      st;

    always_comb begin
        samp_d = probe;
        dly_d  = samp_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
            dly_q  <= '0;
        end else begin
            samp_q <= samp_d;
            dly_q  <= dly_d;
        end
    end

    trig_match #(.LINES(LINES)) u_cond1 (
        .want   (c1_value),
        .care   (c1_care),
        .sample (samp_q),
        .hit    (hit1)
    );

    trig_match #(.LINES(LINES)) u_cond2 (
        .want   (c2_value),
        .care   (c2_care),
        .sample (samp_q),
        .hit    (hit2)
    );

    trig_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .disarm    (disarm),
        .two_level (two_level),
        .hit1      (hit1),
        .hit2      (hit2),
        .st        (st)
    );

    assign armed      = st.armed;
    assign stage1_met = st.first;
    assign fired      = st.fired;
    assign trig_pulse = st.pulse;
    assign cap_data   = CAPW'({st.pulse, dly_q});
endmodule

// File: rtl/seq_trigger_chk.sv
module seq_trigger_chk #(
    parameter int LINES = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           arm,
    input logic           disarm,
    input logic           two_level,
    input logic           armed,
    input logic           stage1_met,
    input logic           fired,
    input logic           trig_pulse,
    input logic [LINES:0] cap_data
);
    // R4: pulse is one cycle wide
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);

    // R10: a pulse needs the block to have been armed
    p_fire_needs_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(armed));

    // R8: disarm clears all status
    p_disarm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> (!armed && !stage1_met && !fired && !trig_pulse));

    // R6: in the sequenced mode the first stage was already met
    p_stage_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_pulse && $past(two_level)) |-> $past(stage1_met));

    // R7: no second pulse while the fired latch holds
    p_fire_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !arm) |=> !trig_pulse);

    // R7: fired latch is sticky without a command
    p_fired_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !arm && !disarm) |=> fired);

    // R9: capture word carries the pulse
    p_cap_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_data[LINES] == trig_pulse);

    // R2: arm from idle sets armed
    p_arm_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !armed && !disarm) |=> (armed && !fired && !stage1_met));
endmodule

bind seq_trigger seq_trigger_chk #(.LINES(LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm        (arm),
    .disarm     (disarm),
    .two_level  (two_level),
    .armed      (armed),
    .stage1_met (stage1_met),
    .fired      (fired),
    .trig_pulse (trig_pulse),
    .cap_data   (cap_data)
);

// File: tb/sim_seq_trigger.sv
`timescale 1ns/1ps
module sim_seq_trigger;
    localparam int L = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arm = 1'b0, disarm = 1'b0, two_level = 1'b0;
    logic [L-1:0] c1_value = '0, c1_care = '0, c2_value = '0, c2_care = '0, probe = '0;
    logic         armed, stage1_met, fired, trig_pulse;
    logic [L:0]   cap_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    seq_trigger #(.LINES(L)) u0 (
        .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .two_level(two_level),
        .c1_value(c1_value), .c1_care(c1_care), .c2_value(c2_value), .c2_care(c2_care),
        .probe(probe), .armed(armed), .stage1_met(stage1_met), .fired(fired),
        .trig_pulse(trig_pulse), .cap_data(cap_data)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            summary();
        end
    end

    initial begin
        step(); step();
        // R1 reset state
        chk("R1 armed", 32'(armed), 0);
        chk("R1 stage1", 32'(stage1_met), 0);
        chk("R1 fired", 32'(fired), 0);
        chk("R1 pulse", 32'(trig_pulse), 0);
        rst_n = 1'b1;
        step();

        // R3 R4 R5 R9: exhaustive single-mode sweep
        for (int c = 0; c < 16; c++) begin
            for (int v = 0; v < 16; v++) begin
                for (int p = 0; p < 16; p++) begin
                    logic e;
                    e = (((p ^ v) & c) == 0);
                    c1_care = L'(c); c1_value = L'(v); probe = L'(p);
                    two_level = 1'b0; disarm = 1'b1;
                    step();
                    disarm = 1'b0; arm = 1'b1;
                    step();
                    arm = 1'b0;
                    step();
                    chk("R3 R4 pulse", 32'(trig_pulse), 32'(e));
                    chk("R9 cap", 32'(cap_data), 32'({e, L'(p)}));
                    chk("R5 stage1 low", 32'(stage1_met), 0);
                    chk("R5 armed", 32'(armed), 32'(!e));
                    step();
                    chk("R4 width", 32'(trig_pulse), 0);
                    chk("R7 fired", 32'(fired), 32'(e));
                end
            end
        end

        // R7: no second pulse with matching probe held
        c1_care = 4'hF; c1_value = 4'h3; probe = 4'h3;
        disarm = 1'b1; step(); disarm = 1'b0; arm = 1'b1; step(); arm = 1'b0;
        step();
        chk("R7 first pulse", 32'(trig_pulse), 1);
        for (int k = 0; k < 5; k++) begin
            step();
            chk("R7 no repeat", 32'(trig_pulse), 0);
            chk("R7 fired held", 32'(fired), 1);
        end

        // R10: unarmed, matching probes ignored
        disarm = 1'b1; step(); disarm = 1'b0;
        for (int k = 0; k < 4; k++) begin
            step();
            chk("R10 pulse", 32'(trig_pulse), 0);
            chk("R10 fired", 32'(fired), 0);
        end

        // R6: sequenced mode
        two_level = 1'b1;
        c1_care = 4'hF; c1_value = 4'h5; c2_care = 4'hF; c2_value = 4'hA;
        probe = 4'hA;
        arm = 1'b1; step(); arm = 1'b0;
        chk("R2 armed", 32'(armed), 1);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R6 stage2 early", 32'(trig_pulse), 0);
            chk("R6 stage1 low", 32'(stage1_met), 0);
        end
        probe = 4'h5; step();
        probe = 4'hA; step();
        chk("R6 stage1 up", 32'(stage1_met), 1);
        chk("R6 no pulse yet", 32'(trig_pulse), 0);
        step();
        chk("R6 pulse", 32'(trig_pulse), 1);
        chk("R6 stage1 held", 32'(stage1_met), 1);
        chk("R9 cap seq", 32'(cap_data), 32'({1'b1, 4'hA}));

        // R6: both conditions on the same sample -> fire one cycle later
        c2_care = 4'h0; probe = 4'h0;
        arm = 1'b1; step(); arm = 1'b0;
        chk("R2 rearm clears", 32'({armed, fired, stage1_met}), 32'(3'b100));
        probe = 4'h5; step();
        step();
        chk("R6 same-sample stage1", 32'(stage1_met), 1);
        chk("R6 same-sample no pulse", 32'(trig_pulse), 0);
        step();
        chk("R6 same-sample pulse", 32'(trig_pulse), 1);

        // R11: arm while armed ignored
        c2_care = 4'hF; c2_value = 4'hA; probe = 4'h0;
        disarm = 1'b1; step(); disarm = 1'b0;
        arm = 1'b1; step(); arm = 1'b0;
        probe = 4'h5; step(); probe = 4'h0; step();
        chk("R11 stage1 set", 32'(stage1_met), 1);
        arm = 1'b1; step(); arm = 1'b0;
        chk("R11 stage1 kept", 32'(stage1_met), 1);
        chk("R11 armed kept", 32'(armed), 1);

        // R8: disarm together with arm
        disarm = 1'b1; arm = 1'b1; step(); disarm = 1'b0; arm = 1'b0;
        chk("R8 cleared", 32'({armed, stage1_met, fired, trig_pulse}), 0);

        finished = 1;
        summary();
    end
endmodule